// File: doc/BRIEF.md
# Dual Interval Timer Unit

This block holds two 16-bit down-counting interval timers for a parallel-interface peripheral. Every clock edge is one half of a bus cycle, and the `ph2` input marks whether the current half is the second (phase-2) half. Both counters step down once in each phase-2 half. The underflow from 0x0000 to 0xFFFF is noticed in the phase-1 half that follows. A timer that is armed then raises its flag, so the event lands one and a half bus cycles after the count reaches zero.

Timer 1 has a full 16-bit reload latch. When `free_run` is high it reloads from that latch, in place of the next decrement, after each underflow. When `free_run` is low it disarms after firing once. Timer 2 has only an 8-bit low latch and always fires once. Its counter keeps running down past 0xFFFF after it has fired. A byte-wide register bus writes the latches, arms the timers and reads the counters.

The block drives single-cycle pulses to an interrupt controller that it does not contain. `t1_flag_set` and `t2_flag_set` set the timer flags. `t1_flag_clr` and `t2_flag_clr` clear them.

Timer 1 moves through the states T1_IDLE, T1_ARMED and T1_RELOAD:
- An arming write takes it from any state to T1_ARMED.
- An underflow seen in T1_ARMED goes to T1_RELOAD when `free_run` is high, or to T1_IDLE when it is low.
- The next phase-2 half takes T1_RELOAD back to T1_ARMED, loading the counter from the latch.

Timer 2 moves between T2_IDLE and T2_ARMED:
- An arming write goes to T2_ARMED.
- An underflow seen in T2_ARMED goes to T2_IDLE.

Top module: `dit_timer_unit`

## Requirements
- R1: After reset both timers are in their idle state with no reload pending. No flag pulse appears while the counters run freely from zero.
- R2: A Timer 1 write to address 5 arms a one-shot count of N, where N is the high byte written with the latch low byte below it. `t1_flag_set` then pulses for one cycle after N+1 phase-2 halves, following the next phase-1 half.
- R3: With `free_run` low, Timer 1 fires once and then stays silent until it is re-armed.
- R4: With `free_run` high, the first phase-2 half after an underflow loads the latch in place of a decrement. Successive flags are therefore N+2 phase-2 halves apart.
- R5: A write to address 9 loads Timer 2 with the written byte high and the address-8 latch low. Timer 2 fires after N+1 phase-2 halves, fires only once, and its counter keeps decrementing past 0xFFFF (the high byte reads 0xFF afterwards).
- R6: Addresses 4 and 6 write the Timer 1 latch low byte. Addresses 5 and 7 write its high byte. Address 7 does not arm the timer.
- R7: `t1_flag_clr` pulses in the cycle after a write to address 5 or 7, or a read of address 4. `t2_flag_clr` pulses in the cycle after a write to address 9 or a read of address 8. Other accesses give no pulse.
- R8: `rdata` is combinational and decodes as follows: address 4 gives the Timer 1 counter low byte, 5 its high byte, 6 and 7 the latch low and high bytes, 8 and 9 the Timer 2 counter low and high bytes, and any other address gives 0x00.
- R9: An arming write (address 5 or 9) in the same half as a detected underflow wins. No flag is raised for the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph2 | input | 1 | High when the current half is phase 2 |
| free_run | input | 1 | Timer 1 reloads after underflow when high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data (combinational) |
| t1_flag_set | output | 1 | Timer 1 flag set pulse |
| t2_flag_set | output | 1 | Timer 2 flag set pulse |
| t1_flag_clr | output | 1 | Timer 1 flag clear pulse |
| t2_flag_clr | output | 1 | Timer 2 flag clear pulse |

## Verification
Read data is due in the same cycle as the address, and the bench samples it shortly after the falling edge that drives the address. Clear pulses and flag pulses come from registers, so each is due in the cycle after the edge that causes it. The bench samples them at the next falling edge. Flag latency is measured by counting the phase-2 edges between the arming write and the pulse, so the expected N+1 or N+2 does not depend on which phase the write fell in. The suppression case places its writes on chosen phases, so that the second write lands exactly on the detecting phase-1 edge.

// File: rtl/dit_pkg.sv
`timescale 1ns/1ps
package dit_pkg;
    // Register addresses; their values are part of the bus behaviour.
    localparam logic [3:0] A_T1_LO      = 4'h4;
    localparam logic [3:0] A_T1_HI_LOAD = 4'h5;
    localparam logic [3:0] A_T1_LAT_LO  = 4'h6;
    localparam logic [3:0] A_T1_LAT_HI  = 4'h7;
    localparam logic [3:0] A_T2_LO      = 4'h8;
    localparam logic [3:0] A_T2_HI_LOAD = 4'h9;

    typedef enum logic [1:0] {
        T1_IDLE   = 2'd0,
        T1_ARMED  = 2'd1,
        T1_RELOAD = 2'd2
    } t1_state_e;

    typedef enum logic {
        T2_IDLE  = 1'b0,
        T2_ARMED = 1'b1
    } t2_state_e;
endpackage

// File: rtl/dit_regbus.sv
`timescale 1ns/1ps
module dit_regbus
    import dit_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*DATA_W-1:0]   t1_count,
    input  logic [2*DATA_W-1:0]   t1_latch,
    input  logic [2*DATA_W-1:0]   t2_count,
    output logic                  wr_t1_lat_lo,
    output logic                  wr_t1_lat_hi,
    output logic                  wr_t1_load,
    output logic                  wr_t2_lat_lo,
    output logic                  wr_t2_load,
    output logic [DATA_W-1:0]     rdata,
    output logic                  t1_clr,
    output logic                  t2_clr
);
    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [3:0] code);
        return a == ADDR_W'(code);
    endfunction

    logic t1_clr_d, t2_clr_d;

    // Write decode
    always_comb begin
        wr_t1_lat_lo = wr_en && (hit(addr, A_T1_LO) || hit(addr, A_T1_LAT_LO));
        wr_t1_lat_hi = wr_en && (hit(addr, A_T1_HI_LOAD) || hit(addr, A_T1_LAT_HI));
        wr_t1_load   = wr_en && hit(addr, A_T1_HI_LOAD);
        wr_t2_lat_lo = wr_en && hit(addr, A_T2_LO);
        wr_t2_load   = wr_en && hit(addr, A_T2_HI_LOAD);
    end

    // Clear strobe sources
    always_comb begin
        t1_clr_d = wr_t1_lat_hi || (rd_en && hit(addr, A_T1_LO));
        t2_clr_d = wr_t2_load   || (rd_en && hit(addr, A_T2_LO));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1_clr <= 1'b0;
            t2_clr <= 1'b0;
        end else begin
            t1_clr <= t1_clr_d;
            t2_clr <= t2_clr_d;
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (hit(addr, A_T1_LO))      rdata = t1_count[DATA_W-1:0];
        if (hit(addr, A_T1_HI_LOAD)) rdata = t1_count[2*DATA_W-1:DATA_W];
        if (hit(addr, A_T1_LAT_LO))  rdata = t1_latch[DATA_W-1:0];
        if (hit(addr, A_T1_LAT_HI))  rdata = t1_latch[2*DATA_W-1:DATA_W];
        if (hit(addr, A_T2_LO))      rdata = t2_count[DATA_W-1:0];
        if (hit(addr, A_T2_HI_LOAD)) rdata = t2_count[2*DATA_W-1:DATA_W];
    end
endmodule

// File: rtl/dit_timer1.sv
`timescale 1ns/1ps
module dit_timer1
    import dit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ph2,
    input  logic                  free_run,
    input  logic                  wr_lat_lo,
    input  logic                  wr_lat_hi,
    input  logic                  wr_load,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   count,
    output logic [2*DATA_W-1:0]   latch,
    output logic                  flag_set
);
    localparam int CNT_W = 2 * DATA_W;

    t1_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] prev_q, prev_d;
    logic [CNT_W-1:0] lat_q, lat_d;
    logic             flag_q, flag_d;
    logic             wrapped;

    // Underflow is seen in phase 1: all ones now, zero in the last phase 2.
    assign wrapped = !ph2 && (cnt_q == '1) && (prev_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T1_IDLE;
            cnt_q   <= '0;
            prev_q  <= '0;
            lat_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= prev_d;
            lat_q   <= lat_d;
            flag_q  <= flag_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        prev_d  = prev_q;
        lat_d   = lat_q;
        flag_d  = 1'b0;

        if (wr_lat_lo) lat_d[DATA_W-1:0]     = wdata;
        if (wr_lat_hi) lat_d[CNT_W-1:DATA_W] = wdata;

        if (ph2) prev_d = cnt_q;

        unique case (state_q)
            T1_IDLE: begin
                if (ph2) cnt_d = cnt_q - 1'b1;
            end
            T1_ARMED: begin
                if (ph2) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (wrapped) begin
                    flag_d  = 1'b1;
                    state_d = free_run ? T1_RELOAD : T1_IDLE;
                end
            end
            T1_RELOAD: begin
                if (ph2) begin
                    cnt_d   = lat_q;
                    state_d = T1_ARMED;
                end
            end
            default: state_d = T1_IDLE;
        endcase

        // Arming write overrides count, reload and underflow.
        if (wr_load) begin
            cnt_d   = {wdata, lat_q[DATA_W-1:0]};
            state_d = T1_ARMED;
            flag_d  = 1'b0;
        end
    end

    assign count    = cnt_q;
    assign latch    = lat_q;
    assign flag_set = flag_q;
endmodule

// File: rtl/dit_timer2.sv
`timescale 1ns/1ps
module dit_timer2
    import dit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ph2,
    input  logic                  wr_lat_lo,
    input  logic                  wr_load,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   count,
    output logic                  flag_set
);
    localparam int CNT_W = 2 * DATA_W;

    t2_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] prev_q, prev_d;
    logic [DATA_W-1:0] lat_q, lat_d;
    logic             flag_q, flag_d;
    logic             wrapped;

    assign wrapped = !ph2 && (cnt_q == '1) && (prev_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T2_IDLE;
            cnt_q   <= '0;
            prev_q  <= '0;
            lat_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= prev_d;
            lat_q   <= lat_d;
            flag_q  <= flag_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        prev_d  = prev_q;
        lat_d   = lat_q;
        flag_d  = 1'b0;

        if (wr_lat_lo) lat_d = wdata;

        // Timer 2 always counts, armed or not.
        if (ph2) begin
            prev_d = cnt_q;
            cnt_d  = cnt_q - 1'b1;
        end

        unique case (state_q)
            T2_IDLE: ;
            T2_ARMED: begin
                if (wrapped) begin
                    flag_d  = 1'b1;
                    state_d = T2_IDLE;
                end
            end
            default: state_d = T2_IDLE;
        endcase

        if (wr_load) begin
            cnt_d   = {wdata, lat_q};
            state_d = T2_ARMED;
            flag_d  = 1'b0;
        end
    end

    assign count    = cnt_q;
    assign flag_set = flag_q;
endmodule

// File: rtl/dit_timer_unit.sv
`timescale 1ns/1ps
module dit_timer_unit #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph2,
    input  logic              free_run,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              t1_flag_set,
    output logic              t2_flag_set,
    output logic              t1_flag_clr,
    output logic              t2_flag_clr
);
    localparam int CNT_W = 2 * DATA_W;

    logic             wr_t1_lat_lo, wr_t1_lat_hi, wr_t1_load;
    logic             wr_t2_lat_lo, wr_t2_load;
    logic [CNT_W-1:0] t1_count, t1_latch, t2_count;

    dit_regbus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .t1_count     (t1_count),
        .t1_latch     (t1_latch),
        .t2_count     (t2_count),
        .wr_t1_lat_lo (wr_t1_lat_lo),
        .wr_t1_lat_hi (wr_t1_lat_hi),
        .wr_t1_load   (wr_t1_load),
        .wr_t2_lat_lo (wr_t2_lat_lo),
        .wr_t2_load   (wr_t2_load),
        .rdata        (rdata),
        .t1_clr       (t1_flag_clr),
        .t2_clr       (t2_flag_clr)
    );

    dit_timer1 #(.DATA_W(DATA_W)) u_t1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph2       (ph2),
        .free_run  (free_run),
        .wr_lat_lo (wr_t1_lat_lo),
        .wr_lat_hi (wr_t1_lat_hi),
        .wr_load   (wr_t1_load),
        .wdata     (wdata),
        .count     (t1_count),
        .latch     (t1_latch),
        .flag_set  (t1_flag_set)
    );

    dit_timer2 #(.DATA_W(DATA_W)) u_t2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph2       (ph2),
        .wr_lat_lo (wr_t2_lat_lo),
        .wr_load   (wr_t2_load),
        .wdata     (wdata),
        .count     (t2_count),
        .flag_set  (t2_flag_set)
    );
endmodule

// File: rtl/dit_timer_unit_chk.sv
`timescale 1ns/1ps
module dit_timer_unit_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ph2,
    input logic              free_run,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              t1_flag_set,
    input logic              t2_flag_set,
    input logic              t1_flag_clr,
    input logic              t2_flag_clr
);
    AST_T1_SET_AFTER_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        t1_flag_set |-> $past(!ph2)); // R2
    AST_T1_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        t1_flag_set |=> !t1_flag_set); // R2
    AST_T2_SET_AFTER_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        t2_flag_set |-> $past(!ph2)); // R5
    AST_T1_CLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        t1_flag_clr |-> $past((wr_en && (addr == ADDR_W'(5) || addr == ADDR_W'(7)))
                              || (rd_en && addr == ADDR_W'(4)))); // R7
    AST_T2_CLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        t2_flag_clr |-> $past((wr_en && addr == ADDR_W'(9))
                              || (rd_en && addr == ADDR_W'(8)))); // R7
    AST_T1_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(4)) |=> t1_flag_clr); // R7
    AST_T1_ARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(5)) |=> !t1_flag_set); // R9
    AST_T2_ARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(9)) |=> !t2_flag_set); // R9
endmodule

bind dit_timer_unit dit_timer_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dit_timer_unit.sv
`timescale 1ns/1ps
module sim_dit_timer_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ph2 = 1'b0;
    logic       free_run = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       t1_flag_set, t2_flag_set, t1_flag_clr, t2_flag_clr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ph2 <= 1'b0;
        else        ph2 <= ~ph2;
    end

    dit_timer_unit u0 (
        .clk(clk), .rst_n(rst_n), .ph2(ph2), .free_run(free_run),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .t1_flag_set(t1_flag_set), .t2_flag_set(t2_flag_set),
        .t1_flag_clr(t1_flag_clr), .t2_flag_clr(t2_flag_clr)
    );

    // {wr, addr, data, expected}
    localparam int NVEC = 13;
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 4'h6, 8'h34, 8'h00},
        {1'b1, 4'h7, 8'h12, 8'h00},
        {1'b0, 4'h6, 8'h00, 8'h34},
        {1'b0, 4'h7, 8'h00, 8'h12},
        {1'b1, 4'h4, 8'hAA, 8'h00},
        {1'b0, 4'h6, 8'h00, 8'hAA},
        {1'b1, 4'h8, 8'h55, 8'h00},
        {1'b1, 4'h9, 8'h80, 8'h00},
        {1'b0, 4'h9, 8'h00, 8'h80},
        {1'b1, 4'h5, 8'h40, 8'h00},
        {1'b0, 4'h5, 8'h00, 8'h40},
        {1'b0, 4'h7, 8'h00, 8'h40},
        {1'b0, 4'h3, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; want = -1 for any phase, else the ph2 value of the write edge.
    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input int want);
        while (want >= 0 && ph2 != want[0]) @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Counts phase-2 edges until the selected flag pulse is seen.
    task automatic wait_flag(input bit t2, input int limit, output int p2, output bit got);
        p2 = 0; got = 1'b0;
        for (int i = 0; i < limit; i++) begin
            if (ph2) p2++;
            @(negedge clk);
            if ((t2 ? t2_flag_set : t1_flag_set) == 1'b1) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic count_pulses(input bit t2, input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((t2 ? t2_flag_set : t1_flag_set) == 1'b1) hits++;
        end
    endtask

    initial begin
        int p2, hits;
        bit got;
        logic [7:0] v;

        repeat (4) @(negedge clk);
        chk("R1 t1_flag_set in reset", int'(t1_flag_set), 0);
        chk("R1 t2_flag_set in reset", int'(t2_flag_set), 0);
        rst_n = 1'b1;
        // R1: counters wrap from zero while disarmed: no pulse.
        count_pulses(1'b0, 20, hits);
        chk("R1 t1 quiet after reset", hits, 0);
        count_pulses(1'b1, 20, hits);
        chk("R1 t2 quiet after reset", hits, 0);

        // Vector table: latch and counter bytes (R6, R8)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][20]) begin
                do_write(VEC[i][19:16], VEC[i][15:8], -1);
            end else begin
                do_read(VEC[i][19:16], v);
                chk($sformatf("R8/R6 vector %0d", i), int'(v), int'(VEC[i][7:0]));
            end
        end

        // R2: one-shot with N=5
        do_write(4'h4, 8'h05, -1);
        do_write(4'h5, 8'h00, -1);
        wait_flag(1'b0, 200, p2, got);
        chk("R2 t1 fired", int'(got), 1);
        chk("R2 t1 phase-2 halves", p2, 6);
        // R3: no second pulse
        count_pulses(1'b0, 40, hits);
        chk("R3 t1 one-shot silent", hits, 0);

        // R4: free-run with N=3
        free_run = 1'b1;
        do_write(4'h4, 8'h03, -1);
        do_write(4'h5, 8'h00, -1);
        wait_flag(1'b0, 200, p2, got);
        chk("R4 first period", p2, 4);
        wait_flag(1'b0, 200, p2, got);
        chk("R4 reload period", p2, 5);
        wait_flag(1'b0, 200, p2, got);
        chk("R4 reload period again", p2, 5);
        free_run = 1'b0;
        wait_flag(1'b0, 200, p2, got);
        chk("R4 pending reload then last shot", p2, 5);
        count_pulses(1'b0, 40, hits);
        chk("R3 stopped after free-run off", hits, 0);

        // R6: address 7 does not arm
        do_write(4'h6, 8'h02, -1);
        do_write(4'h7, 8'h00, -1);
        count_pulses(1'b0, 40, hits);
        chk("R6 address 7 does not arm", hits, 0);
        do_read(4'h6, v);
        chk("R6 latch low via 6", int'(v), 8'h02);

        // R5: Timer 2 with N=4
        do_write(4'h8, 8'h04, -1);
        do_write(4'h9, 8'h00, -1);
        wait_flag(1'b1, 200, p2, got);
        chk("R5 t2 fired", int'(got), 1);
        chk("R5 t2 phase-2 halves", p2, 5);
        count_pulses(1'b1, 40, hits);
        chk("R5 t2 one-shot", hits, 0);
        do_read(4'h9, v);
        chk("R5 t2 keeps counting below FFFF", int'(v), 8'hFF);

        // R7: clear strobes
        do_write(4'h7, 8'h00, -1);
        chk("R7 clr after write 7", int'(t1_flag_clr), 1);
        do_read(4'h4, v);
        chk("R7 clr after read 4", int'(t1_flag_clr), 1);
        do_read(4'h5, v);
        chk("R7 no clr after read 5", int'(t1_flag_clr), 0);
        do_write(4'h9, 8'h40, -1);
        chk("R7 t2 clr after write 9", int'(t2_flag_clr), 1);
        do_read(4'h8, v);
        chk("R7 t2 clr after read 8", int'(t2_flag_clr), 1);
        do_write(4'h8, 8'h00, -1);
        chk("R7 no t2 clr after write 8", int'(t2_flag_clr), 0);

        // R5 corner: N=0 fires after one phase-2 half
        do_write(4'h9, 8'h00, 0);
        wait_flag(1'b1, 50, p2, got);
        chk("R5 zero count halves", p2, 1);

        // R9: re-arm on the detecting phase-1 edge
        do_write(4'h9, 8'h00, 0);
        do_write(4'h9, 8'h10, 0);
        chk("R9 no flag at re-arm", int'(t2_flag_set), 0);
        count_pulses(1'b1, 30, hits);
        chk("R9 old count suppressed", hits, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule